// File: doc/BRIEF.md
# Inter Macroblock Header Bit Estimator

This block estimates how many header bits a candidate inter partitioning of a 16x16 macroblock would cost. It serves the rate term of a rate-distortion block size decision: the caller presents a partition size code, up to four motion vectors, their reference indices and one neighbouring motion vector that acts as the predictor, then pulses `start`. The block copies these inputs and works through the header one element per cycle. It codes the macroblock type first. Then, for each partition in turn, it codes the reference index, the x difference and the y difference.

All element lengths come from one shared length unit that returns Exp-Golomb code lengths. Each motion vector difference goes through the signed-to-unsigned mapping before the unit sees it. The first partition is predicted from the neighbour vector. Each later partition is predicted from the vector of the partition before it. When the last element is summed, the block raises `done` for one cycle, and `bit_total` holds the sum until the next result.

Top module: `hdr_bit_est`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are low and `bit_total` is zero.
- R2: A `start` seen while idle with `part_size` in 0..6 (0=16x16, 1=16x8, 2=8x16, 3=8x8, 4=8x4, 5=4x8, 6=4x4) copies every data input, and `busy` is high from the next cycle.
- R3: The partition count N is 1, 2, 2, 1, 2, 2, 4 for size codes 0..6, and `done` rises exactly 1+3N clock edges after the accepting edge.
- R4: The macroblock type costs 2*floor(log2(c+1))+1 bits, where c is the size code.
- R5: Each used partition's 4-bit reference index r (0..15) costs 2*floor(log2(r+1))+1 bits.
- R6: Each used partition costs 2*floor(log2(2|d|+1))+1 bits for its x difference and the same for its y difference, where d is the vector component minus the predictor component.
- R7: Partition 0 is predicted from `pred_x`/`pred_y`. Partition i>0 is predicted from partition i-1's vector.
- R8: `done` is a one-cycle pulse with `busy` low in that cycle. `bit_total` changes only together with `done`, and it then carries the total of R4 to R6.
- R9: A `start` while `busy` is high has no effect: no change to the result in progress or to its latency.
- R10: A `start` with `part_size` = 7 is ignored: the block stays idle and the output is unchanged.
- R11: A `start` in the cycle where `done` is high is accepted at once. The previous total stays on `bit_total` until the new `done`.
- R12: Partition i uses bits [i*MV_W +: MV_W] of the vector buses and bits [4i +: 4] of `ref_idx`. Slots at or above N have no effect on the total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an estimate of the presented candidate |
| part_size | input | 3 | Partition size code 0..6 |
| mv_x | input | 4*MV_W | Signed x components, partition i in slot i |
| mv_y | input | 4*MV_W | Signed y components, partition i in slot i |
| ref_idx | input | 4*REF_W | Reference indices, partition i in slot i |
| pred_x | input | MV_W | Signed x of neighbouring predictor vector |
| pred_y | input | MV_W | Signed y of neighbouring predictor vector |
| busy | output | 1 | Estimate in progress |
| done | output | 1 | One-cycle completion pulse |
| bit_total | output | TOT_W | Estimated header bits of the last completed candidate |

## Verification
The completion pulse of one candidate and the acceptance of the next can fall in the same cycle. The bench provokes this by asserting `start` with fresh inputs in the cycle where it observes `done`. It then checks that the old total stays on `bit_total` while the new walk runs, and that the new total and latency are exact. A second overlap is a `start` raised in the middle of a walk with different inputs. The bench judges it by the finishing total and the latency, which must both match the first candidate's expected values.

// File: rtl/hbe_pkg.sv
package hbe_pkg;
  localparam int MAXP = 4;
  localparam int PCW  = 3;

  typedef enum logic [1:0] {HC_TYPE, HC_REF, HC_MVX, HC_MVY} hdr_comp_e;

  function automatic logic [PCW-1:0] parts_of(input logic [2:0] sz);
    case (sz)
      3'd0: return 3'd1;
      3'd1: return 3'd2;
      3'd2: return 3'd2;
      3'd3: return 3'd1;
      3'd4: return 3'd2;
      3'd5: return 3'd2;
      3'd6: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic size_legal(input logic [2:0] sz);
    return sz != 3'd7;
  endfunction

  // unsigned Exp-Golomb code length
  function automatic logic [6:0] ue_len(input logic [31:0] v);
    logic [32:0] x;
    logic [5:0]  msb;
    x   = {1'b0, v} + 33'd1;
    msb = '0;
    for (int i = 0; i < 33; i++)
      if (x[i]) msb = 6'(i);
    return 7'({msb, 1'b1});
  endfunction

  // signed value to Exp-Golomb code number
  function automatic logic [31:0] se_to_code(input logic signed [31:0] v);
    if (v > 0) return 32'(2 * v - 1);
    else       return 32'(-2 * v);
  endfunction
endpackage

// File: rtl/hbe_seq.sv
module hbe_seq
  import hbe_pkg::*;
#(
  parameter int NP = MAXP,
  localparam int PIW = $clog2(NP)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [PCW-1:0] nparts,
  output logic           active,
  output hdr_comp_e      comp,
  output logic [PIW-1:0] part,
  output logic           last_step
);
  logic part_end;

  assign part_end  = (PCW'(part) + PCW'(1)) == nparts;
  assign last_step = active && (comp == HC_MVY) && part_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      comp   <= HC_TYPE;
      part   <= '0;
    end else if (go) begin
      active <= 1'b1;
      comp   <= HC_TYPE;
      part   <= '0;
    end else if (active) begin
      if (last_step) begin
        active <= 1'b0;
        comp   <= HC_TYPE;
        part   <= '0;
      end else begin
        case (comp)
          HC_TYPE: comp <= HC_REF;
          HC_REF:  comp <= HC_MVX;
          HC_MVX:  comp <= HC_MVY;
          default: begin
            comp <= HC_REF;
            part <= part + PIW'(1);
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/hbe_codemux.sv
module hbe_codemux
  import hbe_pkg::*;
#(
  parameter int MV_W   = 10,
  parameter int REF_W  = 4,
  parameter int CODE_W = 12,
  localparam int PIW = $clog2(MAXP),
  localparam int DW  = MV_W + 1
) (
  input  logic signed [MV_W-1:0]  mvx  [MAXP],
  input  logic signed [MV_W-1:0]  mvy  [MAXP],
  input  logic        [REF_W-1:0] refi [MAXP],
  input  logic signed [MV_W-1:0]  px0,
  input  logic signed [MV_W-1:0]  py0,
  input  logic        [2:0]       size_code,
  input  hdr_comp_e               comp,
  input  logic        [PIW-1:0]   part,
  output logic        [CODE_W-1:0] code
);
  logic signed [MV_W-1:0] prx [MAXP];
  logic signed [MV_W-1:0] pry [MAXP];
  logic signed [DW-1:0]   dx  [MAXP];
  logic signed [DW-1:0]   dy  [MAXP];

  for (genvar i = 0; i < MAXP; i++) begin : g_pred
    if (i == 0) begin : g_nb
      assign prx[i] = px0;
      assign pry[i] = py0;
    end else begin : g_chain
      assign prx[i] = mvx[i-1];
      assign pry[i] = mvy[i-1];
    end
    assign dx[i] = DW'(mvx[i]) - DW'(prx[i]);
    assign dy[i] = DW'(mvy[i]) - DW'(pry[i]);
  end

  always_comb begin
    case (comp)
      HC_TYPE: code = CODE_W'(size_code);
      HC_REF:  code = CODE_W'(refi[part]);
      HC_MVX:  code = CODE_W'(se_to_code(32'(dx[part])));
      default: code = CODE_W'(se_to_code(32'(dy[part])));
    endcase
  end
endmodule

// File: rtl/hbe_len_lut.sv
module hbe_len_lut
  import hbe_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int LEN_W  = 5
) (
  input  logic [CODE_W-1:0] code,
  output logic [LEN_W-1:0]  len
);
  assign len = LEN_W'(ue_len(32'(code)));
endmodule

// File: rtl/hbe_acc.sv
module hbe_acc #(
  parameter int LEN_W = 5,
  parameter int TOT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_en,
  input  logic             last,
  input  logic [LEN_W-1:0] len,
  output logic [TOT_W-1:0] total,
  output logic             done
);
  logic [TOT_W-1:0] acc;
  logic [TOT_W-1:0] sum;

  assign sum = acc + TOT_W'(len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      total <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clear) acc <= '0;
      else if (add_en) begin
        acc <= sum;
        if (last) begin
          total <= sum;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hdr_bit_est.sv
module hdr_bit_est
  import hbe_pkg::*;
#(
  parameter int MV_W  = 10,
  parameter int REF_W = 4,
  parameter int TOT_W = 10,
  localparam int CODE_W = MV_W + 2,
  localparam int LEN_W  = $clog2(2 * CODE_W + 2),
  localparam int PIW    = $clog2(MAXP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [2:0]             part_size,
  input  logic [MAXP*MV_W-1:0]   mv_x,
  input  logic [MAXP*MV_W-1:0]   mv_y,
  input  logic [MAXP*REF_W-1:0]  ref_idx,
  input  logic [MV_W-1:0]        pred_x,
  input  logic [MV_W-1:0]        pred_y,
  output logic                   busy,
  output logic                   done,
  output logic [TOT_W-1:0]       bit_total
);
  logic                    go;
  logic                    active;
  logic                    last_step;
  hdr_comp_e               comp;
  logic [PIW-1:0]          part;
  logic [CODE_W-1:0]       code_now;
  logic [LEN_W-1:0]        len_now;
  logic [2:0]              size_q;
  logic signed [MV_W-1:0]  mvx_q [MAXP];
  logic signed [MV_W-1:0]  mvy_q [MAXP];
  logic [REF_W-1:0]        ref_q [MAXP];
  logic signed [MV_W-1:0]  prx_q;
  logic signed [MV_W-1:0]  pry_q;

  assign go   = start && !active && size_legal(part_size);
  assign busy = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0;
      prx_q  <= '0;
      pry_q  <= '0;
      for (int i = 0; i < MAXP; i++) begin
        mvx_q[i] <= '0;
        mvy_q[i] <= '0;
        ref_q[i] <= '0;
      end
    end else if (go) begin
      size_q <= part_size;
      prx_q  <= pred_x;
      pry_q  <= pred_y;
      for (int i = 0; i < MAXP; i++) begin
        mvx_q[i] <= mv_x[i*MV_W +: MV_W];
        mvy_q[i] <= mv_y[i*MV_W +: MV_W];
        ref_q[i] <= ref_idx[i*REF_W +: REF_W];
      end
    end
  end

  hbe_seq #(.NP(MAXP)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .nparts(parts_of(size_q)),
    .active(active), .comp(comp), .part(part), .last_step(last_step)
  );

  hbe_codemux #(.MV_W(MV_W), .REF_W(REF_W), .CODE_W(CODE_W)) u_mux (
    .mvx(mvx_q), .mvy(mvy_q), .refi(ref_q), .px0(prx_q), .py0(pry_q),
    .size_code(size_q), .comp(comp), .part(part), .code(code_now)
  );

  hbe_len_lut #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_len (
    .code(code_now), .len(len_now)
  );

  hbe_acc #(.LEN_W(LEN_W), .TOT_W(TOT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(go), .add_en(active),
    .last(last_step), .len(len_now), .total(bit_total), .done(done)
  );
endmodule

// File: rtl/hdr_bit_est_chk.sv
module hdr_bit_est_chk
  import hbe_pkg::*;
#(
  parameter int TOT_W = 10,
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       part_size,
  input logic             busy,
  input logic             done,
  input logic [TOT_W-1:0] bit_total,
  input logic [2:0]       size_q,
  input logic [LEN_W-1:0] len_now
);
  logic [4:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     busy_cnt <= '0;
    else if (busy)  busy_cnt <= busy_cnt + 5'd1;
    else            busy_cnt <= '0;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(bit_total));
  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == 5'(1 + 3 * parts_of(size_q))));
  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && part_size != 3'd7) |=> busy);
  // R10
  illegal_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && part_size == 3'd7) |=> !busy);
  // R6
  odd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> len_now[0]);
endmodule

bind hdr_bit_est hdr_bit_est_chk #(.TOT_W(TOT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .part_size(part_size),
  .busy(busy), .done(done), .bit_total(bit_total), .size_q(size_q),
  .len_now(len_now)
);

// File: tb/sim_hdr_bit_est.sv
`timescale 1ns/1ps
module sim_hdr_bit_est;
  localparam int MV_W = 10;
  localparam int REF_W = 4;
  localparam int TOT_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] part_size = '0;
  logic [4*MV_W-1:0] mv_x = '0, mv_y = '0;
  logic [4*REF_W-1:0] ref_idx = '0;
  logic [MV_W-1:0] pred_x = '0, pred_y = '0;
  logic busy, done;
  logic [TOT_W-1:0] bit_total;

  int total_checks = 0;
  int bad_checks = 0;
  int sz_s;
  int sx[4], sy[4], sr[4];
  int spx, spy;

  always #4 clk = ~clk;

  hdr_bit_est #(.MV_W(MV_W), .REF_W(REF_W), .TOT_W(TOT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .part_size(part_size),
    .mv_x(mv_x), .mv_y(mv_y), .ref_idx(ref_idx), .pred_x(pred_x),
    .pred_y(pred_y), .busy(busy), .done(done), .bit_total(bit_total)
  );

  function automatic int ue_bits(input int v);
    int x = v + 1;
    int n = 0;
    while (x > 1) begin x = x / 2; n++; end
    return 2 * n + 1;
  endfunction

  function automatic int se_bits(input int d);
    int a = (d < 0) ? -d : d;
    int x = 2 * a + 1;
    int n = 0;
    while (x > 1) begin x = x / 2; n++; end
    return 2 * n + 1;
  endfunction

  function automatic int nparts(input int s);
    case (s)
      0, 3: return 1;
      6: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic int expect_total();
    int t = ue_bits(sz_s);
    int qx = spx, qy = spy;
    for (int i = 0; i < nparts(sz_s); i++) begin
      t += ue_bits(sr[i]) + se_bits(sx[i] - qx) + se_bits(sy[i] - qy);
      qx = sx[i];
      qy = sy[i];
    end
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_inputs();
    part_size = 3'(sz_s);
    pred_x = MV_W'(spx);
    pred_y = MV_W'(spy);
    for (int i = 0; i < 4; i++) begin
      mv_x[i*MV_W +: MV_W] = MV_W'(sx[i]);
      mv_y[i*MV_W +: MV_W] = MV_W'(sy[i]);
      ref_idx[i*REF_W +: REF_W] = REF_W'(sr[i]);
    end
  endtask

  task automatic rand_inputs(input int sz, input int span);
    sz_s = sz;
    spx = $urandom_range(0, 2 * span) - span;
    spy = $urandom_range(0, 2 * span) - span;
    for (int i = 0; i < 4; i++) begin
      sx[i] = $urandom_range(0, 2 * span) - span;
      sy[i] = $urandom_range(0, 2 * span) - span;
      sr[i] = $urandom_range(0, 15);
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 40) begin
      @(posedge clk); @(negedge clk); n++;
    end
  endtask

  // launch at a negedge, leaves at the negedge after the accepting edge
  task automatic launch();
    put_inputs();
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_one(input string tag);
    int exp_t, exp_n, n;
    exp_t = expect_total();
    exp_n = 1 + 3 * nparts(sz_s);
    launch();
    check(busy === 1'b1, {tag, " R2 busy"}, int'(busy), 1);
    wait_done(n);
    check(n == exp_n, {tag, " R3 latency"}, n, exp_n);
    check(int'(bit_total) == exp_t, {tag, " R4 R5 R6 R7 total"}, int'(bit_total), exp_t);
    check(busy === 1'b0, {tag, " R8 busy at done"}, int'(busy), 0);
    @(posedge clk); @(negedge clk);
    check(done === 1'b0, {tag, " R8 pulse"}, int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad_checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

  initial begin
    int n, old_t, exp_a, exp_b;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 flags in reset", int'(busy) + int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1 busy", int'(busy), 0);
    check(done === 1'b0, "R1 done", int'(done), 0);
    check(bit_total === '0, "R1 total", int'(bit_total), 0);

    // directed: all zero, each size
    for (int s = 0; s < 7; s++) begin
      sz_s = s; spx = 0; spy = 0;
      for (int i = 0; i < 4; i++) begin sx[i] = 0; sy[i] = 0; sr[i] = 0; end
      run_one("zero");
    end
    // extremes: largest differences, ref 15
    for (int s = 0; s < 7; s++) begin
      sz_s = s; spx = -512; spy = 511;
      for (int i = 0; i < 4; i++) begin
        sx[i] = (i % 2 == 0) ? 511 : -512;
        sy[i] = (i % 2 == 0) ? -512 : 511;
        sr[i] = 15;
      end
      run_one("extreme R5 R6");
    end
    // R7 chain: equal vectors give 1-bit differences after partition 0
    sz_s = 6; spx = 3; spy = -2;
    for (int i = 0; i < 4; i++) begin sx[i] = 3; sy[i] = -2; sr[i] = 1; end
    run_one("R7 chain");
    // R12 unused slots: size 0 with noisy slots 1..3
    sz_s = 0; spx = 1; spy = 1; sx[0] = 2; sy[0] = 0; sr[0] = 2;
    for (int i = 1; i < 4; i++) begin sx[i] = 400; sy[i] = -300; sr[i] = 14; end
    run_one("R12 unused");

    // random
    for (int k = 0; k < 60; k++) begin
      rand_inputs($urandom_range(0, 6), (k % 3 == 0) ? 512 : 6);
      if (sx[0] > 511) sx[0] = 511;
      for (int i = 0; i < 4; i++) begin
        if (sx[i] > 511) sx[i] = 511;
        if (sy[i] > 511) sy[i] = 511;
      end
      if (spx > 511) spx = 511;
      if (spy > 511) spy = 511;
      run_one("random");
    end

    // R10 illegal size
    old_t = int'(bit_total);
    sz_s = 7;
    launch();
    check(busy === 1'b0, "R10 stays idle", int'(busy), 0);
    repeat (5) @(negedge clk);
    check(done === 1'b0 && int'(bit_total) == old_t, "R10 total unchanged", int'(bit_total), old_t);

    // R9 start while busy
    rand_inputs(6, 40);
    exp_a = expect_total();
    launch();
    repeat (3) @(negedge clk);
    rand_inputs(1, 300);
    put_inputs();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    check(n + 4 == 13, "R9 latency kept", n + 4, 13);
    check(int'(bit_total) == exp_a, "R9 total kept", int'(bit_total), exp_a);
    @(negedge clk);

    // R11 back-to-back at done
    rand_inputs(4, 100);
    exp_a = expect_total();
    launch();
    wait_done(n);
    check(int'(bit_total) == exp_a, "R11 first total", int'(bit_total), exp_a);
    rand_inputs(2, 100);
    exp_b = expect_total();
    launch();
    check(busy === 1'b1, "R11 accepted at done", int'(busy), 1);
    check(int'(bit_total) == exp_a, "R11 old total held", int'(bit_total), exp_a);
    wait_done(n);
    check(n == 7, "R11 second latency", n, 7);
    check(int'(bit_total) == exp_b, "R11 second total", int'(bit_total), exp_b);

    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end
endmodule